// File: doc/BRIEF.md
# Dual-Segment Waveform Playback Sequencer

This block plays stored waveforms out of a 1024-word, 32-bit memory. Two segment descriptors each define an address window (low and high bound), a step-rate reload word and a 3-bit sequencing mode. An edge on the trigger input starts playback. The direction of the edge chooses the descriptor: a rising edge selects descriptor 0 and a falling edge selects descriptor 1. Any later edge restarts the sequencer at once.

Once started, an address counter walks the selected window on the baseband clock. Each word read from the memory is split into an I sample (upper half) and a Q sample (lower half). A destination control chooses how the samples leave the block:
- To the scaling path, as raw unsigned 16-bit fractions. The address then advances once per step-rate period.
- To the data path, as signed values widened to 18 bits. The address then advances every cycle, and a flag tells the external parallel port to stand down.

Descriptor fields, the enable and the destination are written into shadow registers. They become active only on an update strobe. A simple write port loads the memory.

Top module: `wavseg_player`

## Requirements
- R1: After reset, ram_addr, seg_active, seq_done, seq_err, par_port_off and all four sample outputs are zero.
- R2: A word written through the memory write port is read back during playback: bits 31:16 form the I sample and bits 15:0 form the Q sample of that address.
- R3: With playback enabled, a 0-to-1 trigger edge starts the sequence of descriptor 0 and a 1-to-0 edge starts descriptor 1. seg_active shows 0 or 1 from the cycle after the edge. An edge during a running sequence restarts it.
- R4: Descriptor, enable and destination writes change nothing until io_update is pulsed. The active copies take the shadow values on the clock edge where io_update is high.
- R5: When the destination is the scaling path, the address moves once every R cycles, where R is the descriptor's step-rate word and a word of 0 behaves as 1. When the destination is the data path, the step-rate word is ignored and the address moves every cycle.
- R6: With the data path selected (ctl_wr_to_bb=1), par_port_off is 1 and the scaling outputs are 0. bb_i and bb_q then carry the 16-bit sample in bits 17:2, with bits 1:0 both equal to bit 15 of the sample, which is the same as the signed sample times 4 plus 3 when it is negative. With the scaling path selected, par_port_off is 0, the bb outputs are 0 and scale_i and scale_q carry the raw samples.
- R7: Mode codes are as follows. 000 counts up from the low bound and stops at the high bound. 001 starts at the high bound and counts down to the low bound. 010 counts up and wraps from the high bound back to the low bound. 011 bounces between the two bounds, reversing on each one. Codes 100 to 111 behave as 000.
- R8: When a single-pass mode (000, 001 or 100 to 111) has output its last address, seq_done rises on the next step and the address holds. A new trigger clears seq_done.
- R9: If the selected descriptor's high bound is not greater than its low bound, the edge sets seq_err and loads the low bound, and the address does not move. A trigger on a valid descriptor clears seq_err.
- R10: While the active enable is 0, trigger edges start nothing and ram_addr and seg_active hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_update | input | 1 | Copies all shadow registers to the active set |
| seg_wr | input | 1 | Writes one shadow descriptor |
| seg_wr_idx | input | 1 | Descriptor selected by seg_wr (0 or 1) |
| seg_wr_lo | input | 10 | Low address bound |
| seg_wr_hi | input | 10 | High address bound |
| seg_wr_rate | input | 16 | Step-rate reload word |
| seg_wr_mode | input | 3 | Sequencing mode code |
| ctl_wr | input | 1 | Writes the shadow enable and destination |
| ctl_wr_enable | input | 1 | Playback enable |
| ctl_wr_to_bb | input | 1 | 1: data path destination, 0: scaling path |
| ram_wr | input | 1 | Memory write strobe |
| ram_wr_addr | input | 10 | Memory write address |
| ram_wr_data | input | 32 | Memory write data |
| trig | input | 1 | Playback trigger; edge direction selects the descriptor |
| ram_addr | output | 10 | Current playback address |
| scale_i | output | 16 | Unsigned I sample to the scaling path |
| scale_q | output | 16 | Unsigned Q sample to the scaling path |
| bb_i | output | 18 | Signed widened I sample to the data path |
| bb_q | output | 18 | Signed widened Q sample to the data path |
| par_port_off | output | 1 | High when the data path takes memory samples |
| seg_active | output | 1 | Descriptor in use |
| seq_done | output | 1 | Single-pass sequence finished |
| seq_err | output | 1 | Selected window is invalid |

## Verification
A trigger edge is seen at the first clock edge after it changes, so ram_addr shows the first address one cycle after the edge. Each sample appears one cycle after the address that fetched it, because the memory read is registered. Enable, destination and descriptor changes are visible one cycle after the io_update pulse. The bench drives and samples on the falling clock edge. It compares the sample outputs against the address seen one sample earlier, and it works out each expected address in closed form from the step count, i.e. the cycle count divided by the effective rate.

// File: rtl/wavseg_pkg.sv
package wavseg_pkg;
  localparam int AW     = 10;
  localparam int SW     = 16;
  localparam int RATE_W = 16;
  localparam int MODE_W = 3;
  localparam int EXT    = 2;
  localparam int DW     = 2 * SW;
  localparam int BW     = SW + EXT;
  localparam int DEPTH  = 1 << AW;

  localparam logic [MODE_W-1:0] MODE_UP   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_DOWN = 3'd1;
  localparam logic [MODE_W-1:0] MODE_LOOP = 3'd2;
  localparam logic [MODE_W-1:0] MODE_PING = 3'd3;

  typedef struct packed {
    logic [AW-1:0]     lo;
    logic [AW-1:0]     hi;
    logic [RATE_W-1:0] rate;
    logic [MODE_W-1:0] mode;
  } seg_desc_t;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          up;
    logic          stop;
  } step_t;

  function automatic logic [RATE_W-1:0] rate_reload(input logic [RATE_W-1:0] r);
    return (r == '0) ? '0 : r - 1'b1;
  endfunction

  function automatic logic [BW-1:0] widen_bb(input logic [SW-1:0] s);
    return {s, {EXT{s[SW-1]}}};
  endfunction

  function automatic logic window_ok(input seg_desc_t d);
    return d.hi > d.lo;
  endfunction

  function automatic step_t step_addr(input logic [MODE_W-1:0] m, input logic up,
                                      input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                      input logic [AW-1:0] hi);
    step_t r;
    r.addr = a;
    r.up   = up;
    r.stop = 1'b0;
    case (m)
      MODE_DOWN: begin
        if (a <= lo) r.stop = 1'b1;
        else         r.addr = a - 1'b1;
      end
      MODE_LOOP: r.addr = (a >= hi) ? lo : a + 1'b1;
      MODE_PING: begin
        if (up) begin
          if (a >= hi) begin r.addr = a - 1'b1; r.up = 1'b0; end
          else         r.addr = a + 1'b1;
        end else begin
          if (a <= lo) begin r.addr = a + 1'b1; r.up = 1'b1; end
          else         r.addr = a - 1'b1;
        end
      end
      default: begin
        if (a >= hi) r.stop = 1'b1;
        else         r.addr = a + 1'b1;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wavseg_regs.sv
module wavseg_regs
  import wavseg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd,
  input  logic      desc_we,
  input  logic      desc_idx,
  input  seg_desc_t desc_in,
  input  logic      ctl_we,
  input  logic      en_in,
  input  logic      bb_in,
  output seg_desc_t act0,
  output seg_desc_t act1,
  output logic      act_en,
  output logic      act_bb
);
  seg_desc_t shd [2];
  seg_desc_t act [2];
  logic      shd_en, shd_bb;

  for (genvar g = 0; g < 2; g++) begin : g_desc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd[g] <= '0;
        act[g] <= '0;
      end else begin
        if (desc_we && (desc_idx == 1'(g))) shd[g] <= desc_in;
        if (upd) act[g] <= shd[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_en <= 1'b0;
      shd_bb <= 1'b0;
      act_en <= 1'b0;
      act_bb <= 1'b0;
    end else begin
      if (ctl_we) begin
        shd_en <= en_in;
        shd_bb <= bb_in;
      end
      if (upd) begin
        act_en <= shd_en;
        act_bb <= shd_bb;
      end
    end
  end

  assign act0 = act[0];
  assign act1 = act[1];
endmodule

// File: rtl/wavseg_trig.sv
module wavseg_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rise,
  output logic fall
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig;
  end

  assign rise = trig & ~trig_q;
  assign fall = ~trig & trig_q;
endmodule

// File: rtl/wavseg_seq.sv
module wavseg_seq
  import wavseg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          to_bb,
  input  logic          rise,
  input  logic          fall,
  input  seg_desc_t     d0,
  input  seg_desc_t     d1,
  output logic [AW-1:0] addr,
  output logic          seg,
  output logic          run,
  output logic          tick,
  output logic          done,
  output logic          err
);
  logic [RATE_W-1:0] cnt;
  logic              dir_up;
  seg_desc_t         cur, nxt_d;
  step_t             nxt;
  logic              start;

  assign start = en && (rise || fall);
  assign nxt_d = fall ? d1 : d0;
  assign cur   = seg ? d1 : d0;
  assign tick  = run && (to_bb || (cnt == '0));
  assign nxt   = step_addr(cur.mode, dir_up, addr, cur.lo, cur.hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      cnt    <= '0;
      dir_up <= 1'b1;
      seg    <= 1'b0;
      run    <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else if (!en) begin
      run <= 1'b0;
    end else if (start) begin
      seg  <= fall;
      done <= 1'b0;
      cnt  <= rate_reload(nxt_d.rate);
      if (!window_ok(nxt_d)) begin
        addr <= nxt_d.lo;
        err  <= 1'b1;
        run  <= 1'b0;
      end else begin
        err <= 1'b0;
        run <= 1'b1;
        if (nxt_d.mode == MODE_DOWN) begin
          addr   <= nxt_d.hi;
          dir_up <= 1'b0;
        end else begin
          addr   <= nxt_d.lo;
          dir_up <= 1'b1;
        end
      end
    end else if (run) begin
      if (tick) begin
        cnt    <= rate_reload(cur.rate);
        addr   <= nxt.addr;
        dir_up <= nxt.up;
        if (nxt.stop) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wavseg_store.sv
module wavseg_store
  import wavseg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic          to_bb,
  output logic [SW-1:0] sc_i,
  output logic [SW-1:0] sc_q,
  output logic [BW-1:0] bb_i,
  output logic [BW-1:0] bb_q
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_word;
  logic [SW-1:0] s_i, s_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_word <= '0;
    else        rd_word <= mem[raddr];
  end

  assign s_i  = rd_word[DW-1:SW];
  assign s_q  = rd_word[SW-1:0];
  assign sc_i = to_bb ? '0 : s_i;
  assign sc_q = to_bb ? '0 : s_q;
  assign bb_i = to_bb ? widen_bb(s_i) : '0;
  assign bb_q = to_bb ? widen_bb(s_q) : '0;
endmodule

// File: rtl/wavseg_player.sv
module wavseg_player
  import wavseg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_update,
  input  logic          seg_wr,
  input  logic          seg_wr_idx,
  input  logic [AW-1:0] seg_wr_lo,
  input  logic [AW-1:0] seg_wr_hi,
  input  logic [RATE_W-1:0] seg_wr_rate,
  input  logic [MODE_W-1:0] seg_wr_mode,
  input  logic          ctl_wr,
  input  logic          ctl_wr_enable,
  input  logic          ctl_wr_to_bb,
  input  logic          ram_wr,
  input  logic [AW-1:0] ram_wr_addr,
  input  logic [DW-1:0] ram_wr_data,
  input  logic          trig,
  output logic [AW-1:0] ram_addr,
  output logic [SW-1:0] scale_i,
  output logic [SW-1:0] scale_q,
  output logic [BW-1:0] bb_i,
  output logic [BW-1:0] bb_q,
  output logic          par_port_off,
  output logic          seg_active,
  output logic          seq_done,
  output logic          seq_err
);
  seg_desc_t desc_in, act0, act1;
  logic      en_w, bb_w, rise_w, fall_w, run_w, tick_w;

  assign desc_in = '{lo: seg_wr_lo, hi: seg_wr_hi, rate: seg_wr_rate, mode: seg_wr_mode};

  wavseg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .upd(io_update),
    .desc_we(seg_wr), .desc_idx(seg_wr_idx), .desc_in(desc_in),
    .ctl_we(ctl_wr), .en_in(ctl_wr_enable), .bb_in(ctl_wr_to_bb),
    .act0(act0), .act1(act1), .act_en(en_w), .act_bb(bb_w)
  );

  wavseg_trig u_trig (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rise(rise_w), .fall(fall_w)
  );

  wavseg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en_w), .to_bb(bb_w),
    .rise(rise_w), .fall(fall_w), .d0(act0), .d1(act1),
    .addr(ram_addr), .seg(seg_active), .run(run_w), .tick(tick_w),
    .done(seq_done), .err(seq_err)
  );

  wavseg_store u_store (
    .clk(clk), .rst_n(rst_n), .we(ram_wr), .waddr(ram_wr_addr), .wdata(ram_wr_data),
    .raddr(ram_addr), .to_bb(bb_w),
    .sc_i(scale_i), .sc_q(scale_q), .bb_i(bb_i), .bb_q(bb_q)
  );

  assign par_port_off = bb_w;
endmodule

// File: rtl/wavseg_sva.sv
module wavseg_sva
  import wavseg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          en_w,
  input logic          rise_w,
  input logic          fall_w,
  input logic          run_w,
  input logic          tick_w,
  input logic [AW-1:0] ram_addr,
  input logic          seg_active,
  input logic          seq_done,
  input logic          seq_err,
  input logic          par_port_off,
  input logic [BW-1:0] bb_i,
  input logic [BW-1:0] bb_q,
  input logic [SW-1:0] scale_i,
  input logic [SW-1:0] scale_q
);
  a_r3_rise_selects_seg0: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w && rise_w) |=> (seg_active == 1'b0));

  a_r3_fall_selects_seg1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w && fall_w) |=> (seg_active == 1'b1));

  a_r5_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !tick_w && !(rise_w || fall_w)) |=> $stable(ram_addr));

  a_r8_done_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !rise_w && !fall_w) |=> $stable(ram_addr));

  a_r9_err_not_running: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !run_w);

  a_r6_bb_quiet_when_scaling: assert property (@(posedge clk) disable iff (!rst_n)
    !par_port_off |-> (bb_i == '0 && bb_q == '0));

  a_r6_scale_quiet_when_bb: assert property (@(posedge clk) disable iff (!rst_n)
    par_port_off |-> (scale_i == '0 && scale_q == '0));

  a_r10_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |=> ($stable(ram_addr) && $stable(seg_active)));
endmodule

bind wavseg_player wavseg_sva u_sva (
  .clk(clk), .rst_n(rst_n), .en_w(en_w), .rise_w(rise_w), .fall_w(fall_w),
  .run_w(run_w), .tick_w(tick_w), .ram_addr(ram_addr), .seg_active(seg_active),
  .seq_done(seq_done), .seq_err(seq_err), .par_port_off(par_port_off),
  .bb_i(bb_i), .bb_q(bb_q), .scale_i(scale_i), .scale_q(scale_q)
);

// File: tb/wavseg_player_tb.sv
module wavseg_player_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_update = 1'b0;
  logic        seg_wr = 1'b0;
  logic        seg_wr_idx = 1'b0;
  logic [9:0]  seg_wr_lo = '0;
  logic [9:0]  seg_wr_hi = '0;
  logic [15:0] seg_wr_rate = '0;
  logic [2:0]  seg_wr_mode = '0;
  logic        ctl_wr = 1'b0;
  logic        ctl_wr_enable = 1'b0;
  logic        ctl_wr_to_bb = 1'b0;
  logic        ram_wr = 1'b0;
  logic [9:0]  ram_wr_addr = '0;
  logic [31:0] ram_wr_data = '0;
  logic        trig = 1'b0;
  logic [9:0]  ram_addr;
  logic [15:0] scale_i, scale_q;
  logic [17:0] bb_i, bb_q;
  logic        par_port_off, seg_active, seq_done, seq_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wavseg_player u_dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int a);
    logic [15:0] i, q;
    i = a[0] ? (16'h8000 | 16'(a)) : (16'h0100 + 16'(a));
    q = 16'hC000 ^ 16'(a << 6);
    return {i, q};
  endfunction

  function automatic logic [17:0] bb_of(input logic [15:0] s);
    int v;
    v = $signed(s) * 4 + (s[15] ? 3 : 0);
    return 18'(v);
  endfunction

  function automatic int exp_addr(input int mode, input int s, input int e, input int k);
    int span, p;
    span = e - s;
    case (mode)
      1: return (e - k < s) ? s : e - k;
      2: return s + (k % (span + 1));
      3: begin
        p = k % (2 * span);
        return (p <= span) ? s + p : e - (p - span);
      end
      default: return (s + k > e) ? e : s + k;
    endcase
  endfunction

  task automatic set_desc(input bit idx, input int lo, input int hi, input int rate, input int mode);
    @(negedge clk);
    seg_wr = 1'b1; seg_wr_idx = idx;
    seg_wr_lo = 10'(lo); seg_wr_hi = 10'(hi); seg_wr_rate = 16'(rate); seg_wr_mode = 3'(mode);
    @(negedge clk);
    seg_wr = 1'b0;
  endtask

  task automatic set_ctl(input bit en, input bit bb);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wr_enable = en; ctl_wr_to_bb = bb;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk);
    io_update = 1'b1;
    @(negedge clk);
    io_update = 1'b0;
  endtask

  task automatic drive_trig(input bit v);
    @(negedge clk);
    trig = v;
  endtask

  task automatic run_seq(input string tag, input int mode, input int s, input int e,
                         input int r, input bit bb, input bit seg, input int n);
    int re, k, kp, a;
    bit single;
    logic [31:0] w;
    re = bb ? 1 : ((r == 0) ? 1 : r);
    single = (mode != 2) && (mode != 3);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      k = i / re;
      check({tag, " R7 address"}, 64'(ram_addr), 64'(exp_addr(mode, s, e, k)));
      check({tag, " R8 done"}, 64'(seq_done), 64'(single && (k > e - s)));
      check({tag, " R9 err clear"}, 64'(seq_err), 64'(0));
      check({tag, " R3 seg"}, 64'(seg_active), 64'(seg));
      check({tag, " R6 port off"}, 64'(par_port_off), 64'(bb));
      if (i > 0) begin
        kp = (i - 1) / re;
        a = exp_addr(mode, s, e, kp);
        w = word_of(a);
        if (bb) begin
          check({tag, " R6 R2 bb_i"}, 64'(bb_i), 64'(bb_of(w[31:16])));
          check({tag, " R6 R2 bb_q"}, 64'(bb_q), 64'(bb_of(w[15:0])));
          check({tag, " R6 scale zero"}, 64'({scale_i, scale_q}), 64'(0));
        end else begin
          check({tag, " R6 R2 scale_i"}, 64'(scale_i), 64'(w[31:16]));
          check({tag, " R6 R2 scale_q"}, 64'(scale_q), 64'(w[15:0]));
          check({tag, " R6 bb zero"}, 64'({bb_i, bb_q}), 64'(0));
        end
      end
    end
  endtask

  task automatic t_reset();
    check("R1 ram_addr", 64'(ram_addr), 64'(0));
    check("R1 flags", 64'({seg_active, seq_done, seq_err, par_port_off}), 64'(0));
    check("R1 samples", 64'({scale_i, scale_q, bb_i, bb_q}), 64'(0));
  endtask

  task automatic t_load_mem();
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      ram_wr = 1'b1; ram_wr_addr = 10'(a); ram_wr_data = word_of(a);
    end
    @(negedge clk);
    ram_wr = 1'b0;
  endtask

  task automatic t_update_gate();
    set_desc(1'b0, 4, 8, 0, 0);
    set_ctl(1'b1, 1'b1);
    drive_trig(1'b1);
    repeat (3) @(negedge clk);
    check("R4 R10 no start before update", 64'(ram_addr), 64'(0));
    check("R4 port flag before update", 64'(par_port_off), 64'(0));
    drive_trig(1'b0);
    repeat (2) @(negedge clk);
    check("R10 fall ignored when disabled", 64'({seg_active, ram_addr}), 64'(0));
    pulse_update();
    check("R4 port flag after update", 64'(par_port_off), 64'(1));
    drive_trig(1'b1);
    run_seq("R7 up", 0, 4, 8, 0, 1'b1, 1'b0, 8);
  endtask

  task automatic t_fall_down();
    set_desc(1'b1, 10, 14, 0, 1);
    pulse_update();
    drive_trig(1'b0);
    run_seq("R7 down", 1, 10, 14, 0, 1'b1, 1'b1, 8);
  endtask

  task automatic t_loop();
    set_desc(1'b0, 20, 23, 0, 2);
    pulse_update();
    drive_trig(1'b1);
    run_seq("R7 loop", 2, 20, 23, 0, 1'b1, 1'b0, 10);
  endtask

  task automatic t_ping();
    set_desc(1'b1, 30, 33, 0, 3);
    pulse_update();
    drive_trig(1'b0);
    run_seq("R7 ping", 3, 30, 33, 0, 1'b1, 1'b1, 14);
  endtask

  task automatic t_scale_rate();
    set_ctl(1'b1, 1'b0);
    set_desc(1'b0, 40, 43, 3, 0);
    pulse_update();
    drive_trig(1'b1);
    run_seq("R5 rate3", 0, 40, 43, 3, 1'b0, 1'b0, 15);
  endtask

  task automatic t_rate_zero();
    set_desc(1'b1, 44, 46, 0, 7);
    pulse_update();
    drive_trig(1'b0);
    run_seq("R5 rate0 R7 code7", 7, 44, 46, 0, 1'b0, 1'b1, 6);
  endtask

  task automatic t_bb_ignores_rate();
    set_ctl(1'b1, 1'b1);
    set_desc(1'b0, 50, 53, 5, 0);
    pulse_update();
    drive_trig(1'b1);
    run_seq("R5 bb ignores rate", 0, 50, 53, 5, 1'b1, 1'b0, 6);
  endtask

  task automatic t_err();
    set_desc(1'b1, 12, 12, 0, 2);
    pulse_update();
    drive_trig(1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 err flag", 64'(seq_err), 64'(1));
      check("R9 address held", 64'(ram_addr), 64'(12));
      check("R9 no done", 64'(seq_done), 64'(0));
    end
  endtask

  task automatic t_retrigger();
    set_desc(1'b0, 0, 60, 0, 2);
    set_desc(1'b1, 5, 9, 0, 0);
    pulse_update();
    drive_trig(1'b1);
    run_seq("R3 R9 restart", 2, 0, 60, 0, 1'b1, 1'b0, 3);
    drive_trig(1'b0);
    run_seq("R3 retrigger", 0, 5, 9, 0, 1'b1, 1'b1, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_mem();
    t_update_gate();
    t_fall_down();
    t_loop();
    t_ping();
    t_scale_rate();
    t_rate_zero();
    t_bb_ignores_rate();
    t_err();
    t_retrigger();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule